// File: doc/BRIEF.md
# Wired Interrupt Aggregation Controller

The block gathers 32 interrupt lines into one pending-event word and drives a single wired interrupt towards a parent controller. Software reaches it through a one-cycle register port (address, write enable, write data, read enable, read data). Each source has its own block bit. A pending bit can be cleared by software, or forced by software so that a source fires again. A message-request output follows the wired output. A control bit can hold that request low.

The trigger mode applies to every source at once and takes one of two states. In `TRIG_LEVEL`, a source that reads high in a cycle marks itself pending in that cycle. In `TRIG_EDGE`, only a low-to-high change of the sampled input marks it pending. Writing control bit 3 moves between the two modes: `TRIG_LEVEL -> TRIG_EDGE` when the bit is written 1, and `TRIG_EDGE -> TRIG_LEVEL` when it is written 0. Each input goes through one sampling register. A history register tracks that sampled value on every cycle, whatever the mode.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, the pending word reads 0, the block word reads 0xFFFFFFFF, the control word reads 0, and both irq_out and msg_req are low.
- R2: When control bit 3 is 0 (level mode), a source that is sampled high sets its pending bit on every cycle. A software clear has no lasting effect while that input stays high.
- R3: When control bit 3 is 1 (edge mode), a pending bit is set only on a 0-to-1 change of the sampled input. The bit then stays set after the input falls, until software clears it.
- R4: A write to offset 0x00 clears each pending bit whose written bit is 0 and leaves unchanged each pending bit whose written bit is 1.
- R5: A write to offset 0x08 sets each pending bit whose written bit is 1. A read of offset 0x08 returns 0.
- R6: The block word is at offset 0x10, where bit value 1 blocks a source. irq_out is registered and is high exactly one cycle after a cycle in which some pending bit is 1 and its block bit is 0.
- R7: A read of offset 0x00 returns the raw pending bits, whatever the block word holds.
- R8: msg_req follows irq_out in the same cycle while control bit 5 was 0 in the previous cycle. It is held low while that bit was 1.
- R9: If a hardware set and a software clear hit the same pending bit in the same cycle, the bit ends up set.
- R10: Switching from level mode to edge mode while an input is held high does not set its pending bit again after it is cleared.
- R11: Writes to unmapped offsets change nothing, and reads of unmapped offsets return 0. The control word (offset 0x28) keeps and returns only bits 3 and 5.
- R12: rd_data is registered: it carries the addressed value one cycle after rd_en, and it is 0 after any cycle with rd_en low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | 32 | Interrupt source lines |
| addr | input | 6 | Byte offset of the register access |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Read data, valid one cycle after rd_en |
| irq_out | output | 1 | Wired interrupt to the parent controller |
| msg_req | output | 1 | Message-signalled interrupt request |

## Verification
The sources are exercised in several ways:
- held high in level mode, with software clearing them under load;
- pulsed in edge mode, so that a latched event can be told apart from a level that is still present;
- held high across a mode switch, which shows whether the history register makes a false edge.

A rising edge is also timed to meet a software clear in the same cycle, to show which of the two wins. Masked and unmasked forced bits show the difference between the raw read-back and the wired output. The same pending state is observed with control bit 5 set and with it clear, to separate the two outputs.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
    localparam int NSRC        = 32;
    localparam int ADDR_W      = 6;
    localparam int OFF_PEND    = 'h00;
    localparam int OFF_FORCE   = 'h08;
    localparam int OFF_BLOCK   = 'h10;
    localparam int OFF_CTRL    = 'h28;
    localparam int CTRL_EDGE_B = 3;
    localparam int CTRL_NOMSG_B = 5;

    typedef enum logic {
        TRIG_LEVEL = 1'b0,
        TRIG_EDGE  = 1'b1
    } trig_mode_e;
endpackage

// File: rtl/irqagg_detect.sv
module irqagg_detect
    import irqagg_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] irq_in,
    input  trig_mode_e   mode,
    output logic [N-1:0] hw_set
);
    logic [N-1:0] samp_q;
    logic [N-1:0] hist_q;

    for (genvar i = 0; i < N; i++) begin : g_src
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                samp_q[i] <= 1'b0;
                hist_q[i] <= 1'b0;
            end else begin
                samp_q[i] <= irq_in[i];
                hist_q[i] <= samp_q[i];
            end
        end

        always_comb begin
            unique case (mode)
                TRIG_LEVEL: hw_set[i] = samp_q[i];
                TRIG_EDGE:  hw_set[i] = samp_q[i] & ~hist_q[i];
                default:    hw_set[i] = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/irqagg_cause.sv
module irqagg_cause #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] hw_set,
    input  logic         clr_we,
    input  logic         force_we,
    input  logic [N-1:0] wdata,
    output logic [N-1:0] cause_q
);
    logic [N-1:0] keep;
    logic [N-1:0] sw_set;
    logic [N-1:0] cause_d;

    always_comb begin
        keep    = clr_we ? wdata : '1;
        sw_set  = force_we ? wdata : '0;
        // set sources are ORed after the clear so a set never loses
        cause_d = (cause_q & keep) | sw_set | hw_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cause_q <= '0;
        else        cause_q <= cause_d;
    end
endmodule

// File: rtl/irqagg_regs.sv
module irqagg_regs
    import irqagg_pkg::*;
#(
    parameter int N  = NSRC,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          wr_en,
    input  logic [N-1:0]  wr_data,
    input  logic          rd_en,
    input  logic [N-1:0]  cause_q,
    output logic [N-1:0]  block_q,
    output trig_mode_e    mode_q,
    output logic          nomsg_q,
    output logic          clr_we,
    output logic          force_we,
    output logic [N-1:0]  rd_data
);
    localparam logic [AW-1:0] A_PEND  = AW'(OFF_PEND);
    localparam logic [AW-1:0] A_FORCE = AW'(OFF_FORCE);
    localparam logic [AW-1:0] A_BLOCK = AW'(OFF_BLOCK);
    localparam logic [AW-1:0] A_CTRL  = AW'(OFF_CTRL);

    logic         block_we;
    logic         ctrl_we;
    logic [N-1:0] rd_mux;
    trig_mode_e   mode_d;

    always_comb begin
        clr_we   = wr_en && (addr == A_PEND);
        force_we = wr_en && (addr == A_FORCE);
        block_we = wr_en && (addr == A_BLOCK);
        ctrl_we  = wr_en && (addr == A_CTRL);
    end

    // trigger mode transitions: LEVEL->EDGE on bit 3 written 1, EDGE->LEVEL on 0
    always_comb begin
        mode_d = mode_q;
        if (ctrl_we) begin
            unique case (mode_q)
                TRIG_LEVEL: if (wr_data[CTRL_EDGE_B])  mode_d = TRIG_EDGE;
                TRIG_EDGE:  if (!wr_data[CTRL_EDGE_B]) mode_d = TRIG_LEVEL;
                default:    mode_d = TRIG_LEVEL;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            block_q <= '1;
            mode_q  <= TRIG_LEVEL;
            nomsg_q <= 1'b0;
        end else begin
            mode_q <= mode_d;
            if (block_we) block_q <= wr_data;
            if (ctrl_we)  nomsg_q <= wr_data[CTRL_NOMSG_B];
        end
    end

    always_comb begin
        rd_mux = '0;
        unique case (addr)
            A_PEND:  rd_mux = cause_q;
            A_BLOCK: rd_mux = block_q;
            A_CTRL: begin
                rd_mux[CTRL_EDGE_B]  = (mode_q == TRIG_EDGE);
                rd_mux[CTRL_NOMSG_B] = nomsg_q;
            end
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= rd_mux;
        else            rd_data <= '0;
    end
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irqagg_pkg::*;
#(
    parameter int N  = NSRC,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  irq_in,
    input  logic [AW-1:0] addr,
    input  logic          wr_en,
    input  logic [N-1:0]  wr_data,
    input  logic          rd_en,
    output logic [N-1:0]  rd_data,
    output logic          irq_out,
    output logic          msg_req
);
    logic [N-1:0] hw_set;
    logic [N-1:0] cause_q;
    logic [N-1:0] block_q;
    trig_mode_e   mode_q;
    logic         nomsg_q;
    logic         clr_we;
    logic         force_we;
    logic         live;

    irqagg_detect #(.N(N)) u_detect (
        .clk    (clk),
        .rst_n  (rst_n),
        .irq_in (irq_in),
        .mode   (mode_q),
        .hw_set (hw_set)
    );

    irqagg_cause #(.N(N)) u_cause (
        .clk      (clk),
        .rst_n    (rst_n),
        .hw_set   (hw_set),
        .clr_we   (clr_we),
        .force_we (force_we),
        .wdata    (wr_data),
        .cause_q  (cause_q)
    );

    irqagg_regs #(.N(N), .AW(AW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (addr),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .rd_en    (rd_en),
        .cause_q  (cause_q),
        .block_q  (block_q),
        .mode_q   (mode_q),
        .nomsg_q  (nomsg_q),
        .clr_we   (clr_we),
        .force_we (force_we),
        .rd_data  (rd_data)
    );

    assign live = |(cause_q & ~block_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_out <= 1'b0;
            msg_req <= 1'b0;
        end else begin
            irq_out <= live;
            msg_req <= live & ~nomsg_q;
        end
    end
endmodule

// File: rtl/irqagg_chk.sv
module irqagg_chk
    import irqagg_pkg::*;
#(
    parameter int N  = NSRC,
    parameter int AW = ADDR_W
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] addr,
    input logic          wr_en,
    input logic [N-1:0]  wr_data,
    input logic          rd_en,
    input logic [N-1:0]  rd_data,
    input logic          irq_out,
    input logic          msg_req,
    input logic [N-1:0]  cause_q,
    input logic [N-1:0]  block_q,
    input logic          nomsg_q
);
    // R8
    msg_implies_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msg_req |-> irq_out);

    // R8
    msg_held_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(nomsg_q) |-> !msg_req);

    // R6
    irq_follows_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_out == (|($past(cause_q) & ~$past(block_q)))));

    // R5
    force_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == AW'(OFF_FORCE)) |=> ((cause_q & $past(wr_data)) == $past(wr_data)));

    // R12
    rd_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (rd_data == '0));

    // R11
    unmapped_block_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr != AW'(OFF_BLOCK)) |=> $stable(block_q));
endmodule

bind irq_aggregator irqagg_chk #(.N(N), .AW(AW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_en   (rd_en),
    .rd_data (rd_data),
    .irq_out (irq_out),
    .msg_req (msg_req),
    .cause_q (cause_q),
    .block_q (block_q),
    .nomsg_q (nomsg_q)
);

// File: tb/tb_irq_aggregator.sv
`timescale 1ns/1ps
module tb_irq_aggregator;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_in = '0;
    logic [5:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;
    logic        irq_out;
    logic        msg_req;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    string phase = "R1";

    always #2 clk = ~clk;

    irq_aggregator dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .addr(addr),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(rd_data), .irq_out(irq_out), .msg_req(msg_req)
    );

    // behavioural reference model
    bit [31:0] m_samp, m_hist, m_pend, m_block, m_rd;
    bit        m_edge, m_nomsg, m_irq, m_msg;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_samp = 0; m_hist = 0; m_pend = 0; m_block = 32'hFFFF_FFFF;
            m_edge = 0; m_nomsg = 0; m_irq = 0; m_msg = 0; m_rd = 0;
        end else begin
            bit [31:0] ev;
            bit [31:0] nxt;
            bit        any;
            ev  = m_edge ? (m_samp & ~m_hist) : m_samp;
            any = (m_pend & ~m_block) != 0;
            m_rd = 0;
            if (rd_en) begin
                if (addr == 6'h00) m_rd = m_pend;
                else if (addr == 6'h10) m_rd = m_block;
                else if (addr == 6'h28) m_rd = {26'd0, m_nomsg, 1'b0, m_edge, 3'd0};
            end
            m_irq = any;
            m_msg = any && !m_nomsg;
            nxt = m_pend;
            if (wr_en && addr == 6'h00) nxt = nxt & wr_data;
            if (wr_en && addr == 6'h08) nxt = nxt | wr_data;
            m_pend = nxt | ev;
            if (wr_en && addr == 6'h10) m_block = wr_data;
            if (wr_en && addr == 6'h28) begin
                m_edge  = wr_data[3];
                m_nomsg = wr_data[5];
            end
            m_hist = m_samp;
            m_samp = irq_in;
        end
    end

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // compare against the model on every clock
    always @(posedge clk) begin
        #1;
        if (rst_n && !done) begin
            check(phase, "irq_out vs model", {31'd0, irq_out}, {31'd0, m_irq});
            check(phase, "msg_req vs model", {31'd0, msg_req}, {31'd0, m_msg});
            check(phase, "rd_data vs model", rd_data, m_rd);
        end
    end

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] v);
        addr = a; rd_en = 1'b1;
        @(posedge clk); #1;
        v = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        phase = "R1";
        check("R1", "irq_out after reset", {31'd0, irq_out}, 0);
        check("R1", "msg_req after reset", {31'd0, msg_req}, 0);
        rd(6'h00, v); check("R1", "pending reset", v, 32'h0);
        rd(6'h10, v); check("R1", "block reset", v, 32'hFFFF_FFFF);
        rd(6'h28, v); check("R1", "control reset", v, 32'h0);

        // R2 level mode
        phase = "R2";
        irq_in = 32'h5; idle(3);
        rd(6'h00, v); check("R2", "level sets pending", v, 32'h5);
        // R6 unblock bit 0
        phase = "R6";
        wr(6'h10, 32'hFFFF_FFFE); idle(2);
        check("R6", "irq_out high when unblocked", {31'd0, irq_out}, 1);
        check("R8", "msg_req follows irq_out", {31'd0, msg_req}, 1);
        phase = "R2";
        wr(6'h00, 32'h0); idle(1);
        rd(6'h00, v); check("R2", "clear under high level has no effect", v, 32'h5);
        irq_in = 32'h0; idle(2);
        wr(6'h00, 32'h0); idle(2);
        rd(6'h00, v); check("R2", "clear after input low", v, 32'h0);
        check("R6", "irq_out low after clear", {31'd0, irq_out}, 0);

        // R7 raw read regardless of block; R6 blocked source silent
        phase = "R7";
        wr(6'h08, 32'h8000_0000); idle(2);
        rd(6'h00, v); check("R7", "raw read of blocked bit", v, 32'h8000_0000);
        check("R6", "blocked bit keeps irq_out low", {31'd0, irq_out}, 0);
        // R5 force register reads zero
        phase = "R5";
        rd(6'h08, v); check("R5", "force reads zero", v, 32'h0);
        // R4 selective clear
        phase = "R4";
        wr(6'h08, 32'h0000_00F0);
        wr(6'h00, 32'h0000_0030); idle(1);
        rd(6'h00, v); check("R4", "write-zero clears only zero bits", v, 32'h30);
        wr(6'h00, 32'h0); idle(1);
        rd(6'h00, v); check("R4", "clear all", v, 32'h0);

        // R8 message suppression
        phase = "R8";
        wr(6'h28, 32'h20);
        wr(6'h10, ~32'h10);
        wr(6'h08, 32'h10); idle(2);
        check("R8", "irq_out with suppression", {31'd0, irq_out}, 1);
        check("R8", "msg_req suppressed", {31'd0, msg_req}, 0);
        wr(6'h28, 32'h0); idle(2);
        check("R8", "msg_req restored", {31'd0, msg_req}, 1);
        wr(6'h00, 32'h0); idle(2);

        // R10 mode switch with input held high
        phase = "R10";
        irq_in = 32'h2; idle(3);
        wr(6'h28, 32'h8);
        wr(6'h00, 32'h0); idle(3);
        rd(6'h00, v); check("R10", "no false edge after mode switch", v, 32'h0);
        rd(6'h28, v); check("R10", "edge mode readback", v, 32'h8);

        // R3 edge latching
        phase = "R3";
        irq_in = 32'h0; idle(2);
        irq_in = 32'h2; idle(1);
        irq_in = 32'h0; idle(3);
        rd(6'h00, v); check("R3", "edge latched after input falls", v, 32'h2);
        wr(6'h00, 32'h0); idle(2);
        rd(6'h00, v); check("R3", "edge cleared stays clear", v, 32'h0);

        // R9 set beats clear in same cycle
        phase = "R9";
        irq_in = 32'h4;
        @(negedge clk);
        wr(6'h00, 32'h0); idle(1);
        rd(6'h00, v); check("R9", "hardware set wins over clear", v, 32'h4);
        irq_in = 32'h0;
        wr(6'h00, 32'h0); idle(2);

        // R11 unmapped offsets and control width
        phase = "R11";
        wr(6'h18, 32'h0);
        wr(6'h04, 32'h0); idle(1);
        rd(6'h18, v); check("R11", "unmapped read zero", v, 32'h0);
        rd(6'h10, v); check("R11", "block unchanged by unmapped write", v, ~32'h10);
        rd(6'h00, v); check("R11", "pending unchanged by unmapped write", v, 32'h0);
        wr(6'h28, 32'hFFFF_FFFF);
        rd(6'h28, v); check("R11", "control keeps bits 3 and 5", v, 32'h28);
        wr(6'h28, 32'h0);

        // R12 read data returns to zero
        phase = "R12";
        idle(1);
        check("R12", "rd_data idle zero", rd_data, 32'h0);
        idle(2);
        finish_run();
    end
endmodule